// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the register interface that software uses to drive one PS/2 keyboard or mouse port. It occupies a 4 KB window on a simple 32-bit bus. The bus is word-addressed, so the block sees a 10-bit word index. On the device side, an external deserializer hands over received bytes through a valid/ready pair. An external serializer takes bytes to send from a one-cycle strobe. The line-level PS/2 clock and data handling lives outside the block.

A received byte is held as pending until software reads the data word. That read copies the byte into a "last byte" register and returns it. The parity flag in the status word is the XOR of the last byte. Software also sees a control word, a clock-divisor word, an interrupt-status word and eight identification bytes at the top of the window. A single interrupt output combines "byte pending and receive interrupt enabled" with a control bit that forces the interrupt high directly.

Read data is registered. It appears on `bus_rdata` one clock after the read request, and all other outputs also change on that clock edge.

Top module: `ps2_regif`

## Requirements
- R1: After synchronous reset, control, divisor, last byte and the pending flag are all 0, `irq` is 0, `tx_strobe` is 0 and `rx_ready` is 1.
- R2: Word 0 (control) and word 3 (divisor) store all 32 written bits, and a read returns the stored value.
- R3: Word 1 (status) reads with bit 6 always 1 and bit 4 equal to the pending flag. Bits 5, 3, 1, 0 and bits 31..7 always read 0.
- R4: Status bit 2 equals the XOR of all 8 bits of the last byte returned by a data read. It is 0 after reset.
- R5: A read of word 2 (data) while a byte is pending returns that byte and stores it as the last byte. With nothing pending, the read returns the last byte again.
- R6: `rx_ready` is 1 when nothing is pending or a data read is in the same cycle. A byte offered while `rx_ready` is 0 is dropped. A data read clears the pending flag unless a byte is accepted in the same cycle, in which case that new byte stays pending.
- R7: `irq` equals (pending AND control bit 4) OR control bit 3. It is updated on the same edge that changes the pending flag or the control word.
- R8: Word 4 (interrupt status) reads as 0x2 | pending: bit 1 is always 1 and bit 0 is the pending flag.
- R9: A write to word 2 pulses `tx_strobe` for one cycle, with `tx_byte` equal to the low 8 bits of the write data. Any other bus cycle leaves `tx_strobe` at 0.
- R10: Words 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in increasing address order.
- R11: Reads of words 5 to 0x3F7 return 0. Writes to any word other than 0, 2 and 3 change no state and send nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 10 | Word index within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_byte | input | 8 | Offered byte |
| rx_ready | output | 1 | Block can take the offered byte |
| tx_strobe | output | 1 | One-cycle pulse: send `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a byte through every one of the 256 values. Each byte is read back and the status parity bit is checked, so a parity taken from the wrong byte or over too few bits shows up as a wrong bit 2.

It issues a data read in the same cycle that a new byte arrives. A design that cleared pending unconditionally would lose that byte, and one that never opened `rx_ready` would refuse it. It also offers bytes while one is already pending, so an overrun that overwrote the held byte would return the wrong value.

Random control writes toggle the force and enable bits around pending bytes, which catches an interrupt that lags by a cycle or uses the wrong bit. Writes to read-only and unmapped words catch decodes that corrupt control, divisor or the transmit strobe.

// File: rtl/ps2_regif_pkg.sv
package ps2_regif_pkg;
  // word indices of the registers that software sees
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_DATA  = 2;
  localparam int IDX_DIV   = 3;
  localparam int IDX_ISTAT = 4;

  // status word bit positions
  localparam int ST_TX_EMPTY = 6;
  localparam int ST_RX_FULL  = 4;
  localparam int ST_PARITY   = 2;

  // control word bit positions
  localparam int CTL_RX_IE = 4;
  localparam int CTL_FORCE = 3;

  function automatic logic [7:0] ident_byte(input logic [2:0] sel);
    case (sel)
      3'd0:    ident_byte = 8'h50;
      3'd1:    ident_byte = 8'h10;
      3'd2:    ident_byte = 8'h04;
      3'd3:    ident_byte = 8'h00;
      3'd4:    ident_byte = 8'h0D;
      3'd5:    ident_byte = 8'hF0;
      3'd6:    ident_byte = 8'h05;
      default: ident_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ps2_rx_hold.sv
module ps2_rx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              pop,
  output logic              rx_ready,
  output logic              pend_q,
  output logic              pend_nxt,
  output logic [BYTE_W-1:0] head_q,
  output logic [BYTE_W-1:0] last_q
);
  logic take;

  assign rx_ready = ~pend_q | pop;
  assign take     = rx_valid & rx_ready;
  assign pend_nxt = take | (pend_q & ~pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      head_q <= '0;
      last_q <= '0;
    end else begin
      if (pop && pend_q) last_q <= head_q;
      if (take)          head_q <= rx_byte;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/ps2_irq_gen.sv
module ps2_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic pend_nxt,
  input  logic rx_ie_nxt,
  input  logic force_nxt,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (pend_nxt & rx_ie_nxt) | force_nxt;
  end
endmodule

// File: rtl/ps2_ident.sv
module ps2_ident #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        sel,
  output logic [DATA_W-1:0] value
);
  import ps2_regif_pkg::*;
  assign value = DATA_W'(ident_byte(sel));
endmodule

// File: rtl/ps2_regif.sv
module ps2_regif #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-3:0]   bus_word,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                rx_valid,
  input  logic [BYTE_W-1:0]   rx_byte,
  output logic                rx_ready,
  output logic                tx_strobe,
  output logic [BYTE_W-1:0]   tx_byte,
  output logic                irq
);
  import ps2_regif_pkg::*;
  localparam int WORD_W = ADDR_W - 2;

  logic rd_en, wr_en, is_ident, pop;
  logic wr_ctrl, wr_div, wr_data;
  logic [DATA_W-1:0] ctrl_q, ctrl_d, div_q, stat_v, ident_v, rd_mux;
  logic pend_q, pend_nxt;
  logic [BYTE_W-1:0] head_q, last_q;

  assign rd_en    = bus_sel & ~bus_wr;
  assign wr_en    = bus_sel &  bus_wr;
  assign is_ident = &bus_word[WORD_W-1:3];
  assign pop      = rd_en   & (bus_word == WORD_W'(IDX_DATA));
  assign wr_ctrl  = wr_en   & (bus_word == WORD_W'(IDX_CTRL));
  assign wr_div   = wr_en   & (bus_word == WORD_W'(IDX_DIV));
  assign wr_data  = wr_en   & (bus_word == WORD_W'(IDX_DATA));
  assign ctrl_d   = wr_ctrl ? bus_wdata : ctrl_q;

  ps2_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .pop(pop),
    .rx_ready(rx_ready), .pend_q(pend_q), .pend_nxt(pend_nxt),
    .head_q(head_q), .last_q(last_q)
  );

  ps2_irq_gen u_irq (
    .clk(clk), .rst(rst), .pend_nxt(pend_nxt),
    .rx_ie_nxt(ctrl_d[CTL_RX_IE]), .force_nxt(ctrl_d[CTL_FORCE]), .irq(irq)
  );

  ps2_ident #(.DATA_W(DATA_W)) u_ident (.sel(bus_word[2:0]), .value(ident_v));

  always_comb begin
    stat_v              = '0;
    stat_v[ST_TX_EMPTY] = 1'b1;
    stat_v[ST_RX_FULL]  = pend_q;
    stat_v[ST_PARITY]   = ^last_q;
  end

  always_comb begin
    rd_mux = '0;
    if (is_ident) begin
      rd_mux = ident_v;
    end else begin
      case (bus_word)
        WORD_W'(IDX_CTRL):  rd_mux = ctrl_q;
        WORD_W'(IDX_STAT):  rd_mux = stat_v;
        WORD_W'(IDX_DATA):  rd_mux = DATA_W'(pend_q ? head_q : last_q);
        WORD_W'(IDX_DIV):   rd_mux = div_q;
        WORD_W'(IDX_ISTAT): rd_mux = DATA_W'({1'b1, pend_q});
        default:            rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      bus_rdata <= '0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      if (wr_div) div_q <= bus_wdata;
      if (rd_en)  bus_rdata <= rd_mux;
      tx_strobe <= wr_data;
      if (wr_data) tx_byte <= bus_wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/ps2_regif_chk.sv
module ps2_regif_chk #(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [WORD_W-1:0] bus_word,
  input logic [BYTE_W-1:0] wd_lo,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_ready,
  input logic              tx_strobe,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              irq,
  input logic              pend_q,
  input logic              rx_ie,
  input logic              force_irq
);
  logic rd_stat, rd_istat, pop, wr_tx;
  assign rd_stat  = bus_sel & ~bus_wr & (bus_word == WORD_W'(1));
  assign rd_istat = bus_sel & ~bus_wr & (bus_word == WORD_W'(4));
  assign pop      = bus_sel & ~bus_wr & (bus_word == WORD_W'(2));
  assign wr_tx    = bus_sel &  bus_wr & (bus_word == WORD_W'(2));

  // R7
  irq_combine_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ((pend_q & rx_ie) | force_irq));
  // R9
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> (tx_strobe && tx_byte == $past(wd_lo)));
  // R9
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_tx |=> !tx_strobe);
  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !pop) |-> !rx_ready);
  // R3
  stat_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (bus_rdata[6] && !bus_rdata[5] && !bus_rdata[3] &&
                 bus_rdata[1:0] == 2'b00 && bus_rdata[DATA_W-1:7] == '0));
  // R8
  istat_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    rd_istat |=> (bus_rdata[1] && bus_rdata[DATA_W-1:2] == '0));
endmodule

bind ps2_regif ps2_regif_chk #(.WORD_W(ADDR_W-2), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
  .wd_lo(bus_wdata[BYTE_W-1:0]), .bus_rdata(bus_rdata), .rx_ready(rx_ready),
  .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq), .pend_q(pend_q),
  .rx_ie(ctrl_q[4]), .force_irq(ctrl_q[3])
);

// File: tb/test_ps2_regif.sv
`timescale 1ns/1ps
module test_ps2_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0, tx_byte;
  logic        rx_ready, tx_strobe, irq;

  always #2 clk = ~clk;

  ps2_regif i_ps2_regif (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_ctrl, m_div;
  logic [7:0]  m_last, m_head;
  bit          m_pend;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] id_of(input logic [2:0] k);
    logic [7:0] t [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] w);
    if (w >= 10'h3F8) return {24'h0, id_of(w[2:0])};
    case (w)
      10'd0:   return m_ctrl;
      10'd1:   return {25'h0, 1'b1, 1'b0, m_pend, 1'b0, ^m_last, 2'b00};
      10'd2:   return {24'h0, m_pend ? m_head : m_last};
      10'd3:   return m_div;
      10'd4:   return {30'h0, 1'b1, m_pend};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [9:0] w);
    if (w >= 10'h3F8) return "R10 ident";
    case (w)
      10'd0, 10'd3: return "R2 ctrl/div";
      10'd1:        return "R3 status";
      10'd2:        return "R5 data";
      10'd4:        return "R8 istat";
      default:      return "R11 unmapped read";
    endcase
  endfunction

  // one bus cycle; drives at negedge, samples 1 ns after the posedge
  task automatic op(input bit sel, input bit wr, input logic [9:0] w, input logic [31:0] d,
                    input bit push, input logic [7:0] pb);
    logic [31:0] exp;
    bit pop, acc;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_word = w; bus_wdata = d;
    rx_valid = push; rx_byte = pb;
    pop = sel && !wr && (w == 10'd2);
    #1;
    check("R6 rx_ready", {31'h0, rx_ready}, {31'h0, (!m_pend || pop)});
    exp = exp_read(w);
    acc = push && (!m_pend || pop);
    @(posedge clk); #1;
    if (sel && !wr) check(tag_of(w), bus_rdata, exp);
    if (sel && wr && w == 10'd0) m_ctrl = d;
    if (sel && wr && w == 10'd3) m_div = d;
    if (pop && m_pend) m_last = m_head;
    if (acc) begin m_head = pb; m_pend = 1; end
    else if (pop) m_pend = 0;
    if (sel && wr && w == 10'd2) begin
      check("R9 tx strobe", {31'h0, tx_strobe}, 32'h1);
      check("R9 tx byte", {24'h0, tx_byte}, {24'h0, d[7:0]});
    end else begin
      check("R9 tx idle", {31'h0, tx_strobe}, 32'h0);
    end
    check("R7 irq", {31'h0, irq}, {31'h0, (m_pend && m_ctrl[4]) || m_ctrl[3]});
    bus_sel = 0; rx_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ctrl = 0; m_div = 0; m_last = 0; m_head = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 tx_strobe", {31'h0, tx_strobe}, 32'h0);
    check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    op(1, 0, 10'd0, 0, 0, 0);
    op(1, 0, 10'd3, 0, 0, 0);
    op(1, 0, 10'd1, 0, 0, 0);   // R4 parity of reset last byte is 0
    op(1, 0, 10'd2, 0, 0, 0);
    // R10 identification words
    for (int k = 0; k < 8; k++) op(1, 0, 10'h3F8 + 10'(k), 0, 0, 0);
    // R7 force bit, then enable with pending byte
    op(1, 1, 10'd0, 32'h8, 0, 0);
    op(1, 1, 10'd0, 32'h10, 0, 0);
    op(0, 0, 10'd0, 0, 1, 8'hA5);
    op(1, 0, 10'd4, 0, 0, 0);   // R8 pending visible
    // R6 byte offered while pending is dropped
    op(0, 0, 10'd0, 0, 1, 8'h3C);
    // R6 read with simultaneous arrival keeps the new byte pending
    op(1, 0, 10'd2, 0, 1, 8'h7E);
    op(1, 0, 10'd1, 0, 0, 0);
    op(1, 0, 10'd2, 0, 0, 0);
    op(1, 0, 10'd2, 0, 0, 0);   // R5 repeat of last byte
    // R11 writes to read-only / unmapped words
    op(1, 1, 10'd1, 32'hFFFF_FFFF, 0, 0);
    op(1, 1, 10'd4, 32'hFFFF_FFFF, 0, 0);
    op(1, 1, 10'h3FA, 32'hFFFF_FFFF, 0, 0);
    op(1, 1, 10'd77, 32'hFFFF_FFFF, 0, 0);
    op(1, 0, 10'd0, 0, 0, 0);
    op(1, 0, 10'd3, 0, 0, 0);
    op(1, 0, 10'd200, 0, 0, 0);
    op(1, 1, 10'd2, 32'h1234_5699, 0, 0);  // R9
    // R4 parity over every byte value
    for (int v = 0; v < 256; v++) begin
      op(0, 0, 10'd0, 0, 1, 8'(v));
      op(1, 0, 10'd2, 0, 0, 0);
      op(1, 0, 10'd1, 0, 0, 0);
    end
    // random mix, R2 R5 R6 R7 R9 R11
    for (int n = 0; n < 1500; n++) begin
      int sel_op;
      logic [9:0] w;
      sel_op = int'($urandom_range(0, 9));
      case (sel_op)
        0: w = 10'd0;
        1: w = 10'd1;
        2, 3: w = 10'd2;
        4: w = 10'd3;
        5: w = 10'd4;
        6: w = 10'($urandom_range(5, 10'h3F7));
        7: w = 10'h3F8 + 10'($urandom_range(0, 7));
        default: w = 10'($urandom_range(0, 4));
      endcase
      op(($urandom_range(0, 4) != 0), ($urandom_range(0, 2) == 0), w,
         $urandom, ($urandom_range(0, 1) == 1), 8'($urandom));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule